// File: doc/BRIEF.md
# Direct-Mapped Tag-and-Data Cache Controller

This block controls a direct-mapped cache that lives in stacked DRAM. Every set holds one entry that keeps the tag, the valid and dirty bits and a 64-byte line side by side. One stacked-memory read therefore returns everything the lookup needs. The processor side offers one request at a time: a full-line read or a full-line write, addressed by line address. The block answers with a single response pulse. A response carries the line for a read and zero for a write, together with the true hit flag.

A table of 2-bit saturating counters guesses, in the cycle a request is accepted, whether the line is present. For a read predicted to miss, the off-chip read starts in that same cycle, alongside the stacked read. If the guess was wrong and the tag matches, the cache data is returned. The late off-chip answer is then absorbed. If a hit was guessed but the tag misses, the off-chip read starts once the tag compare is done.

On a miss with a dirty victim, the old line goes back to off-chip memory before the new entry replaces it. The stacked and off-chip memories sit outside the block behind simple request and response pins with no back-pressure.

Top module: `tad_cache_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, stk_wr_valid and mem_wr_valid are 0 while no request is presented. Every predictor counter starts at 0.
- R2: A request is accepted in a cycle with req_valid and req_ready both 1. In that cycle stk_rd_valid is 1 and stk_rd_set equals the low SET_W bits of req_addr. No second stacked read is issued before that read's response.
- R3: A read whose returned entry is valid and whose tag (req_addr bits above SET_W) matches gets resp_valid, resp_hit=1 and the stacked data, in the cycle the stacked response arrives.
- R4: Predictor entry i is a 2-bit counter used by lines whose low PRED_W address bits equal i. It counts up on a true hit and down on a true miss, saturating at 3 and 0, for reads and writes alike. It predicts a hit when its value is 2 or 3.
- R5: A read predicted to miss raises mem_rd_valid with mem_rd_addr equal to req_addr in the acceptance cycle. A write never raises mem_rd_valid.
- R6: When an early off-chip read was made for a line that then hits, the cache data is returned and the off-chip data is discarded. req_ready stays 0 until that off-chip response has arrived.
- R7: A read predicted to hit that actually misses issues exactly one off-chip read, after the stacked response. A read predicted to hit that hits issues none.
- R8: On a miss whose victim is valid and dirty, mem_wr_valid pulses once with mem_wr_addr = {victim tag, set} and the victim's stacked data. A clean or invalid victim causes no off-chip write.
- R9: A read miss writes the stacked entry with the new tag, dirty=0 and the off-chip data. The same data is returned with resp_hit=0.
- R10: A write stores req_wdata with the request's tag and dirty=1, whether it hits or misses. It is answered with resp_data=0 and resp_hit giving the true outcome.
- R11: From the cycle after acceptance, req_ready stays 0 until the response (and any absorbed off-chip answer) is done. Exactly one response is produced per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = full-line write, 0 = read |
| req_addr | input | LADDR_W (20) | Line address |
| req_wdata | input | LINE_W (512) | Write line |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | True lookup outcome |
| resp_data | output | LINE_W (512) | Read line, zero for writes |
| stk_rd_valid | output | 1 | Stacked entry read |
| stk_rd_set | output | SET_W (8) | Set read |
| stk_rd_resp_valid | input | 1 | Stacked read answer |
| stk_rd_resp_tag | input | TAG_W (12) | Stored tag |
| stk_rd_resp_vld | input | 1 | Stored valid bit |
| stk_rd_resp_dirty | input | 1 | Stored dirty bit |
| stk_rd_resp_data | input | LINE_W (512) | Stored line |
| stk_wr_valid | output | 1 | Stacked entry write (valid set to 1) |
| stk_wr_set | output | SET_W (8) | Set written |
| stk_wr_tag | output | TAG_W (12) | Tag written |
| stk_wr_dirty | output | 1 | Dirty bit written |
| stk_wr_data | output | LINE_W (512) | Line written |
| mem_rd_valid | output | 1 | Off-chip line read |
| mem_rd_addr | output | LADDR_W (20) | Line address read |
| mem_rd_resp_valid | input | 1 | Off-chip read answer |
| mem_rd_resp_data | input | LINE_W (512) | Off-chip line |
| mem_wr_valid | output | 1 | Off-chip writeback |
| mem_wr_addr | output | LADDR_W (20) | Writeback line address |
| mem_wr_data | output | LINE_W (512) | Writeback line |

## Verification
The bench drives reads that were guessed as misses but hit, with the off-chip answer arriving both before and after the tag compare. A design that forwarded the off-chip line here would return stale data where the cache holds a dirty copy. A design that dropped the late answer would take the next request with a read still in flight.

It also drives guessed hits that miss; a block that never launched the late read would hang. Dirty evictions are followed by a read of the evicted line, so a lost or misaddressed writeback shows up as wrong returned data. The counters are walked through their saturation points, so an off-by-one threshold changes which acceptances raise an early read.

// File: rtl/tad_pkg.sv
package tad_pkg;

    localparam int unsigned LINE_BYTES = 64;
    localparam int unsigned LINE_BITS  = LINE_BYTES * 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_MISS,
        ST_DRAIN
    } ctl_state_e;

    typedef logic [1:0] pctr_t;
    localparam pctr_t PCTR_RESET = 2'd0;

    typedef struct packed {
        logic hit;
        logic wb;
    } tag_verdict_t;

    function automatic pctr_t pctr_step(pctr_t c, logic hit);
        if (hit) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic pctr_says_hit(pctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/tad_pred_table.sv
module tad_pred_table import tad_pkg::*; #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_hit,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_hit
);
    localparam int unsigned N = 1 << IDX_W;

    logic [2*N-1:0] ctr_vec;

    for (genvar g = 0; g < N; g++) begin : g_ctr
        pctr_t c;
        always_ff @(posedge clk) begin
            if (rst)
                c <= PCTR_RESET;
            else if (up_en && up_idx == IDX_W'(g))
                c <= pctr_step(c, up_hit);
        end
        assign ctr_vec[2*g +: 2] = c;
    end

    assign lk_hit = pctr_says_hit(ctr_vec[2*int'(lk_idx) +: 2]);

endmodule

// File: rtl/tad_tag_check.sv
module tad_tag_check import tad_pkg::*; #(
    parameter int unsigned TAG_W = 12
) (
    input  logic [TAG_W-1:0] want_tag,
    input  logic [TAG_W-1:0] have_tag,
    input  logic             have_vld,
    input  logic             have_dirty,
    output tag_verdict_t     verdict
);
    always_comb begin
        verdict.hit = have_vld && (have_tag == want_tag);
        verdict.wb  = have_vld && have_dirty && (have_tag != want_tag);
    end
endmodule

// File: rtl/tad_fill_buf.sv
module tad_fill_buf #(
    parameter int unsigned LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap,
    input  logic [LINE_W-1:0] cap_data,
    output logic              held,
    output logic [LINE_W-1:0] held_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_data <= '0;
        end else if (cap) begin
            held      <= 1'b1;
            held_data <= cap_data;
        end else if (clr) begin
            held      <= 1'b0;
        end
    end
endmodule

// File: rtl/tad_cache_ctrl.sv
module tad_cache_ctrl import tad_pkg::*; #(
    parameter int unsigned LADDR_W = 20,
    parameter int unsigned SET_W   = 8,
    parameter int unsigned PRED_W  = 6,
    parameter int unsigned LINE_W  = LINE_BITS,
    localparam int unsigned TAG_W  = LADDR_W - SET_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [LADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [LINE_W-1:0]  resp_data,
    output logic               stk_rd_valid,
    output logic [SET_W-1:0]   stk_rd_set,
    input  logic               stk_rd_resp_valid,
    input  logic [TAG_W-1:0]   stk_rd_resp_tag,
    input  logic               stk_rd_resp_vld,
    input  logic               stk_rd_resp_dirty,
    input  logic [LINE_W-1:0]  stk_rd_resp_data,
    output logic               stk_wr_valid,
    output logic [SET_W-1:0]   stk_wr_set,
    output logic [TAG_W-1:0]   stk_wr_tag,
    output logic               stk_wr_dirty,
    output logic [LINE_W-1:0]  stk_wr_data,
    output logic               mem_rd_valid,
    output logic [LADDR_W-1:0] mem_rd_addr,
    input  logic               mem_rd_resp_valid,
    input  logic [LINE_W-1:0]  mem_rd_resp_data,
    output logic               mem_wr_valid,
    output logic [LADDR_W-1:0] mem_wr_addr,
    output logic [LINE_W-1:0]  mem_wr_data
);
    ctl_state_e         st_q, st_d;
    logic [LADDR_W-1:0] addr_q;
    logic               write_q;
    logic [LINE_W-1:0]  wdata_q;
    logic               early_q;

    logic               accept, pred_hit, early_now, compare, have_line, fill;
    logic               buf_held;
    logic [LINE_W-1:0]  buf_data, fill_data;
    tag_verdict_t       verdict;

    wire [TAG_W-1:0] cur_tag = addr_q[LADDR_W-1:SET_W];
    wire [SET_W-1:0] cur_set = addr_q[SET_W-1:0];

    tad_pred_table #(.IDX_W(PRED_W)) u_pred (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (req_addr[PRED_W-1:0]),
        .lk_hit (pred_hit),
        .up_en  (compare),
        .up_idx (addr_q[PRED_W-1:0]),
        .up_hit (verdict.hit)
    );

    tad_tag_check #(.TAG_W(TAG_W)) u_tag (
        .want_tag   (cur_tag),
        .have_tag   (stk_rd_resp_tag),
        .have_vld   (stk_rd_resp_vld),
        .have_dirty (stk_rd_resp_dirty),
        .verdict    (verdict)
    );

    tad_fill_buf #(.LINE_W(LINE_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .cap       (mem_rd_resp_valid),
        .cap_data  (mem_rd_resp_data),
        .held      (buf_held),
        .held_data (buf_data)
    );

    // Handshake and lookup launch
    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        accept       = req_ready && req_valid;
        early_now    = accept && !req_write && !pred_hit;
        compare      = (st_q == ST_LOOK) && stk_rd_resp_valid;
        have_line    = buf_held || mem_rd_resp_valid;
        fill         = (st_q == ST_MISS) && have_line;
        fill_data    = buf_held ? buf_data : mem_rd_resp_data;
        stk_rd_valid = accept;
        stk_rd_set   = req_addr[SET_W-1:0];
    end

    // Off-chip traffic
    always_comb begin
        mem_rd_valid = early_now ||
                       (compare && !verdict.hit && !write_q && !early_q);
        mem_rd_addr  = early_now ? req_addr : addr_q;
        mem_wr_valid = compare && verdict.wb;
        mem_wr_addr  = {stk_rd_resp_tag, cur_set};
        mem_wr_data  = stk_rd_resp_data;
    end

    // Stacked writes and responses
    always_comb begin
        stk_wr_valid = (compare && write_q) || fill;
        stk_wr_set   = cur_set;
        stk_wr_tag   = cur_tag;
        stk_wr_dirty = write_q;
        stk_wr_data  = write_q ? wdata_q : fill_data;
        resp_valid   = (compare && (verdict.hit || write_q)) || fill;
        resp_hit     = compare && verdict.hit;
        if (fill)
            resp_data = fill_data;
        else if (compare && verdict.hit && !write_q)
            resp_data = stk_rd_resp_data;
        else
            resp_data = '0;
    end

    // Sequencing
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = ST_LOOK;
            ST_LOOK: begin
                if (compare) begin
                    if (write_q)
                        st_d = ST_IDLE;
                    else if (verdict.hit)
                        st_d = (early_q && !have_line) ? ST_DRAIN : ST_IDLE;
                    else
                        st_d = ST_MISS;
                end
            end
            ST_MISS:  if (have_line) st_d = ST_IDLE;
            ST_DRAIN: if (mem_rd_resp_valid) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            early_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                addr_q  <= req_addr;
                write_q <= req_write;
                wdata_q <= req_wdata;
                early_q <= early_now;
            end
        end
    end

endmodule

// File: rtl/tad_cache_chk.sv
module tad_cache_chk #(
    parameter int unsigned LADDR_W = 20,
    parameter int unsigned SET_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               stk_rd_valid,
    input logic               stk_rd_resp_valid,
    input logic               stk_rd_resp_vld,
    input logic               stk_rd_resp_dirty,
    input logic               stk_wr_valid,
    input logic               mem_rd_valid,
    input logic               mem_rd_resp_valid,
    input logic               mem_wr_valid
);
    logic rd_pending;

    always_ff @(posedge clk) begin
        if (rst)                    rd_pending <= 1'b0;
        else if (mem_rd_valid)      rd_pending <= 1'b1;
        else if (mem_rd_resp_valid) rd_pending <= 1'b0;
    end

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    single_stk_read_chk: assert property (@(posedge clk) disable iff (rst)
        stk_rd_valid |=> !stk_rd_valid);

    // R8
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> (stk_rd_resp_valid && stk_rd_resp_vld && stk_rd_resp_dirty));

    // R3
    hit_at_compare_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> (stk_rd_resp_valid && stk_rd_resp_vld));

    // R10
    stk_write_answered_chk: assert property (@(posedge clk) disable iff (rst)
        stk_wr_valid |-> resp_valid);

    // R6
    ready_needs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !rd_pending);

    // R5
    one_offchip_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !rd_pending);

endmodule

bind tad_cache_ctrl tad_cache_chk #(.LADDR_W(LADDR_W), .SET_W(SET_W)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .resp_valid        (resp_valid),
    .resp_hit          (resp_hit),
    .stk_rd_valid      (stk_rd_valid),
    .stk_rd_resp_valid (stk_rd_resp_valid),
    .stk_rd_resp_vld   (stk_rd_resp_vld),
    .stk_rd_resp_dirty (stk_rd_resp_dirty),
    .stk_wr_valid      (stk_wr_valid),
    .mem_rd_valid      (mem_rd_valid),
    .mem_rd_resp_valid (mem_rd_resp_valid),
    .mem_wr_valid      (mem_wr_valid)
);

// File: tb/test_tad_cache_ctrl.sv
module test_tad_cache_ctrl;
    localparam int LA = 20;
    localparam int SW = 8;
    localparam int TW = LA - SW;
    localparam int PW = 6;
    localparam int LW = 512;
    localparam int NSET = 1 << SW;
    localparam int STK_LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          req_valid = 0, req_write = 0;
    logic [LA-1:0] req_addr = '0;
    logic [LW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, resp_hit;
    logic [LW-1:0] resp_data;
    logic          stk_rd_valid;
    logic [SW-1:0] stk_rd_set;
    logic          stk_rd_resp_valid = 0, stk_rd_resp_vld = 0, stk_rd_resp_dirty = 0;
    logic [TW-1:0] stk_rd_resp_tag = '0;
    logic [LW-1:0] stk_rd_resp_data = '0;
    logic          stk_wr_valid, stk_wr_dirty;
    logic [SW-1:0] stk_wr_set;
    logic [TW-1:0] stk_wr_tag;
    logic [LW-1:0] stk_wr_data;
    logic          mem_rd_valid, mem_wr_valid;
    logic [LA-1:0] mem_rd_addr, mem_wr_addr;
    logic          mem_rd_resp_valid = 0;
    logic [LW-1:0] mem_rd_resp_data = '0;
    logic [LW-1:0] mem_wr_data;

    tad_cache_ctrl i_tad_cache_ctrl (.*);

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] bg(input int unsigned a);
        logic [LW-1:0] r;
        for (int k = 0; k < 16; k++) r[k*32 +: 32] = a * 32'h0100_0193 + k * 32'h11;
        return r;
    endfunction

    // stacked memory model
    logic [TW-1:0] s_tag [NSET];
    bit            s_vld [NSET];
    bit            s_dirty [NSET];
    logic [LW-1:0] s_data [NSET];
    int            s_cnt = 0;
    logic [SW-1:0] s_set;
    initial for (int i = 0; i < NSET; i++) begin
        s_vld[i] = 0; s_dirty[i] = 0; s_tag[i] = '0; s_data[i] = '0;
    end

    always @(posedge clk) begin
        stk_rd_resp_valid <= 1'b0;
        if (stk_wr_valid) begin
            s_tag[stk_wr_set] = stk_wr_tag;   s_vld[stk_wr_set] = 1;
            s_dirty[stk_wr_set] = stk_wr_dirty; s_data[stk_wr_set] = stk_wr_data;
        end
        if (s_cnt > 0) begin
            s_cnt--;
            if (s_cnt == 0) begin
                stk_rd_resp_valid <= 1'b1;
                stk_rd_resp_tag   <= s_tag[s_set];
                stk_rd_resp_vld   <= s_vld[s_set];
                stk_rd_resp_dirty <= s_dirty[s_set];
                stk_rd_resp_data  <= s_data[s_set];
            end
        end
        if (stk_rd_valid) begin s_set = stk_rd_set; s_cnt = STK_LAT; end
    end

    // off-chip memory model
    logic [LW-1:0] o_mem [int unsigned];
    int            o_cnt = 0, off_lat = 6, o_rd_n = 0, o_wr_n = 0;
    logic [LA-1:0] o_addr;
    always @(posedge clk) begin
        mem_rd_resp_valid <= 1'b0;
        if (mem_wr_valid) begin o_mem[mem_wr_addr] = mem_wr_data; o_wr_n++; end
        if (o_cnt > 0) begin
            o_cnt--;
            if (o_cnt == 0) begin
                mem_rd_resp_valid <= 1'b1;
                mem_rd_resp_data  <= o_mem.exists(o_addr) ? o_mem[o_addr] : bg(o_addr);
            end
        end
        if (mem_rd_valid) begin o_addr = mem_rd_addr; o_cnt = off_lat; o_rd_n++; end
    end
    wire o_busy = (o_cnt > 0) || mem_rd_resp_valid;

    // reference state and scoreboard
    typedef struct { logic [LW-1:0] d; bit hit; string tag; } exp_t;
    exp_t exq[$];
    logic [TW-1:0] r_tag [NSET];
    bit            r_vld [NSET];
    bit            r_dirty [NSET];
    logic [LW-1:0] r_data [NSET];
    logic [1:0]    r_ctr [1 << PW];
    logic [LW-1:0] r_mem [int unsigned];
    int exp_rd = 0, exp_wb = 0;
    initial begin
        for (int i = 0; i < NSET; i++) begin r_vld[i] = 0; r_dirty[i] = 0; r_tag[i] = '0; r_data[i] = '0; end
        for (int i = 0; i < (1 << PW); i++) r_ctr[i] = 2'd0;
    end

    function automatic logic [LW-1:0] rm(input int unsigned a);
        return r_mem.exists(a) ? r_mem[a] : bg(a);
    endfunction

    always @(negedge clk) begin
        if (resp_valid) begin
            if (exq.size() == 0) begin
                chk(0, "R11 unexpected extra response", {511'd0, resp_valid}, '0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk(resp_data == e.d, {e.tag, " resp_data"}, resp_data, e.d);
                chk(resp_hit == e.hit, {e.tag, " resp_hit"}, {511'd0, resp_hit}, {511'd0, e.hit});
            end
        end
    end

    task automatic do_req(input bit w, input logic [LA-1:0] a, input logic [LW-1:0] d);
        logic [SW-1:0] set;
        logic [TW-1:0] tag;
        int            pi;
        bit            hit, pred, early;
        exp_t          e;
        set = a[SW-1:0]; tag = a[LA-1:SW]; pi = int'(a[PW-1:0]);
        hit  = r_vld[set] && r_tag[set] == tag;
        pred = r_ctr[pi] >= 2;
        early = !w && !pred;
        if (!hit && r_vld[set] && r_dirty[set]) begin
            r_mem[{r_tag[set], set}] = r_data[set];
            exp_wb++;
        end
        if (!w && (!pred || !hit)) exp_rd++;
        e.hit = hit;
        if (w) begin
            e.d = '0; e.tag = hit ? "R10 write hit" : "R10 write miss";
            r_data[set] = d; r_dirty[set] = 1;
        end else if (hit) begin
            e.d = r_data[set]; e.tag = early ? "R6 mispredicted miss" : "R3 read hit";
        end else begin
            e.d = rm(a); e.tag = pred ? "R7 late fetch fill" : "R9 read fill";
            r_data[set] = e.d; r_dirty[set] = 0;
        end
        r_vld[set] = 1; r_tag[set] = tag;
        r_ctr[pi] = hit ? (r_ctr[pi] == 3 ? 2'd3 : r_ctr[pi] + 2'd1)
                        : (r_ctr[pi] == 0 ? 2'd0 : r_ctr[pi] - 2'd1);
        exq.push_back(e);

        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        chk(req_ready == 1, "R11 ready when idle", {511'd0, req_ready}, 1);
        chk(stk_rd_valid && stk_rd_set == set, "R2 stacked read at accept",
            {503'd0, stk_rd_valid, stk_rd_set}, {503'd0, 1'b1, set});
        chk(mem_rd_valid == early, "R4 R5 early off-chip read", {511'd0, mem_rd_valid}, {511'd0, early});
        if (early) chk(mem_rd_addr == a, "R5 early read address", mem_rd_addr, a);
        @(posedge clk); #1;
        req_valid = 0;
        @(negedge clk);
        chk(req_ready == 0, "R11 busy after accept", {511'd0, req_ready}, 0);
        while (!req_ready) @(negedge clk);
        chk(!o_busy, "R6 off-chip read pending at ready", {511'd0, o_busy}, 0);
        chk(exq.size() == 0, "R11 response before ready", exq.size(), 0);
    endtask

    initial begin
        int unsigned seed;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1 reset ready", {511'd0, req_ready}, 1);
        chk(!resp_valid && !stk_wr_valid && !mem_wr_valid, "R1 quiet after reset",
            {509'd0, resp_valid, stk_wr_valid, mem_wr_valid}, 0);

        off_lat = 6;
        do_req(0, 20'h00105, '0);              // R9 fill, R4 predicted miss
        do_req(0, 20'h00105, '0);              // R6 late off-chip answer absorbed
        do_req(0, 20'h00105, '0);              // R6 again, counter to 2
        do_req(0, 20'h00105, '0);              // R3 R7 hit predicted, no off-chip read
        do_req(1, 20'h00205, ~bg(32'h205));    // R10 write miss, clean victim
        do_req(0, 20'h00305, '0);              // R8 dirty victim, R7 late fetch
        do_req(0, 20'h00205, '0);              // R8 written-back data comes back
        off_lat = 1;
        do_req(0, 20'h00A40, '0);              // off-chip answer before compare
        do_req(1, 20'h00A40, ~bg(32'hA40));    // R10 write hit
        do_req(0, 20'h00A40, '0);              // R6 cache copy wins over stale off-chip
        do_req(1, 20'hFFFFF, bg(32'h5A5A));    // top set and tag
        do_req(0, 20'hFFFFF, '0);
        seed = 32'h1234_5678;
        for (int i = 0; i < 80; i++) begin
            logic [7:0] sets [4];
            logic [LA-1:0] a;
            sets = '{8'h05, 8'h40, 8'hFF, 8'h13};
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = {9'd0, seed[18:16], sets[seed[21:20]]};
            off_lat = seed[24] ? 1 : 7;
            do_req(seed[27:26] == 2'b00, a, bg(seed));
        end
        repeat (10) @(negedge clk);
        chk(o_wr_n == exp_wb, "R8 writeback count", o_wr_n, exp_wb);
        chk(o_rd_n == exp_rd, "R7 off-chip read count", o_rd_n, exp_rd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule